// File: doc/BRIEF.md
# Ring-Oscillator Timestamp Decoder

This block turns one raw time snapshot into a binary timestamp. A snapshot carries the 16-cell state of an inverting ring oscillator, which subdivides each clock period into 32 fine bins, and two 15-bit LFSR coarse values. One coarse register advances on the rising edge of the oscillator clock and the other on the falling edge. At any instant, at least one of the two is stable.

The decoder checks that the ring state is one of the 32 legal thermometer patterns and decodes it to a 5-bit fine bin. It uses the fine bin to pick the coarse value that was stable when the snapshot was taken. It then finds the position of that LFSR state in its sequence with a step-and-compare search. The search walks a local LFSR from the seed instead of storing a table. The result goes out on a valid/ready stream together with error flags. A new snapshot is taken only while the block is idle.

Top module: `ts_decoder_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A ring word whose lowest k bits are 0 and whose other bits are 1 (k = 0 to 16, so 0xFFFF gives 0 and 0x0000 gives 16) decodes to fine bin k.
- R3: A ring word whose lowest j bits are 1 and whose other bits are 0 (j = 1 to 15, so 0x7FFF gives 31) decodes to fine bin 16 + j.
- R4: Any other ring word sets out_err_pattern and forces the fine field to 0. Coarse selection then follows fine bin 0.
- R5: For fine bins 8 to 23, the coarse field is the sequence index of the rising-edge coarse value (coarse_rise).
- R6: For all other fine bins, the coarse field is the index of the falling-edge value (coarse_fall) plus one, modulo 32767. Index 32766 becomes 0.
- R7: The sequence index of a state is the number of steps from seed 0x0001. One step shifts the state left by one and inserts bit14 XOR bit13 at bit 0.
- R8: A selected coarse value that is not in the sequence (0x0000) sets out_err_timeout and gives a coarse field of 0.
- R9: out_valid and out_data hold until out_ready is seen high. in_ready is 0 from the accept cycle until the output has been taken.
- R10: out_data is {coarse_index[14:0], fine[4:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Snapshot present |
| in_ready | output | 1 | Block idle; snapshot taken when in_valid is high |
| ring_state | input | 16 | Ring oscillator cell states, bit i is cell i |
| coarse_rise | input | 15 | Rising-edge LFSR coarse snapshot |
| coarse_fall | input | 15 | Falling-edge LFSR coarse snapshot |
| out_valid | output | 1 | Timestamp available |
| out_ready | input | 1 | Consumer takes the timestamp |
| out_data | output | 20 | {coarse_index, fine} |
| out_err_pattern | output | 1 | Ring word was not a legal pattern |
| out_err_timeout | output | 1 | Coarse state not found in the sequence |

## Verification
The ring input is driven with every legal pattern class: the all-ones and all-zeros ends, the bins on either side of the edges where the coarse choice switches (7/8 and 23/24), and random legal bins. These tell apart the clearing half of the ring cycle from the setting half, and the rising-edge path from the adjusted falling-edge path. Random non-thermometer words separate legal patterns from illegal ones and show that an illegal word is steered onto the falling-edge path. Coarse states are generated from random small indices, which exercises the search and the +1 adjustment. Directed cases cover the last index, where the adjustment wraps to 0, and the zero state, which must end in a timeout. Output hold under back-pressure is checked on every transaction.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int RING_CELLS = 16;
  localparam int COARSE_W   = 15;
  localparam logic [COARSE_W-1:0] LFSR_TAPS = 15'h6000;
  localparam logic [COARSE_W-1:0] LFSR_SEED = 15'h0001;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_OUT    = 2'd2
  } ts_state_e;
endpackage

// File: rtl/ring_phase_decode.sv
module ring_phase_decode #(
  parameter int CELLS  = 16,
  parameter int FINE_W = $clog2(2*CELLS)
) (
  input  logic [CELLS-1:0]  ring,
  output logic [FINE_W-1:0] fine,
  output logic              legal
);
  logic [CELLS-1:0]  folded;
  logic [FINE_W-2:0] ones;

  always_comb begin
    folded = ring[CELLS-1] ? ~ring : ring;
    legal  = ((folded & (folded + 1'b1)) == '0) && !folded[CELLS-1];
    ones   = '0;
    for (int i = 0; i < CELLS; i++) begin
      ones = ones + {{(FINE_W-2){1'b0}}, folded[i]};
    end
    fine = legal ? {~ring[CELLS-1], ones} : '0;
  end
endmodule

// File: rtl/coarse_pick.sv
module coarse_pick #(
  parameter int CELLS  = 16,
  parameter int FINE_W = $clog2(2*CELLS),
  parameter int CW     = 15
) (
  input  logic [FINE_W-1:0] fine,
  input  logic [CW-1:0]     rise_val,
  input  logic [CW-1:0]     fall_val,
  output logic [CW-1:0]     picked,
  output logic              use_fall
);
  localparam int LO = CELLS/2;
  localparam int HI = CELLS/2 + CELLS - 1;

  always_comb begin
    use_fall = !((int'(fine) >= LO) && (int'(fine) <= HI));
    picked   = use_fall ? fall_val : rise_val;
  end
endmodule

// File: rtl/lfsr_rank_engine.sv
module lfsr_rank_engine #(
  parameter int            CW   = 15,
  parameter logic [CW-1:0] TAPS = 15'h6000,
  parameter logic [CW-1:0] SEED = 15'h0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] target,
  output logic          done,
  output logic          timeout,
  output logic [CW-1:0] index
);
  localparam logic [CW-1:0] LAST_IDX = {{(CW-1){1'b1}}, 1'b0};

  logic          running;
  logic [CW-1:0] walker;
  logic [CW-1:0] count;
  logic [CW-1:0] goal;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      walker  <= SEED;
      count   <= '0;
      goal    <= '0;
      index   <= '0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (start) begin
        running <= 1'b1;
        walker  <= SEED;
        count   <= '0;
        goal    <= target;
      end else if (running) begin
        if (walker == goal) begin
          running <= 1'b0;
          done    <= 1'b1;
          index   <= count;
        end else if (count == LAST_IDX) begin
          running <= 1'b0;
          timeout <= 1'b1;
        end else begin
          walker <= {walker[CW-2:0], ^(walker & TAPS)};
          count  <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ts_decoder_top.sv
module ts_decoder_top
  import ts_pkg::*;
#(
  parameter int            CELLS  = RING_CELLS,
  parameter int            CW     = COARSE_W,
  parameter logic [CW-1:0] TAPS   = LFSR_TAPS,
  parameter logic [CW-1:0] SEED   = LFSR_SEED,
  parameter int            FINE_W = $clog2(2*CELLS),
  parameter int            OUT_W  = CW + FINE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CELLS-1:0] ring_state,
  input  logic [CW-1:0]    coarse_rise,
  input  logic [CW-1:0]    coarse_fall,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_err_pattern,
  output logic             out_err_timeout
);
  localparam logic [CW-1:0] LAST_IDX = {{(CW-1){1'b1}}, 1'b0};

  ts_state_e         state;
  logic [FINE_W-1:0] dec_fine;
  logic              dec_legal;
  logic [CW-1:0]     pick_val;
  logic              pick_fall;
  logic              accept;
  logic              eng_done;
  logic              eng_timeout;
  logic [CW-1:0]     eng_index;
  logic [FINE_W-1:0] hold_fine;
  logic              hold_bad;
  logic              hold_fall;
  logic [CW-1:0]     adj_index;

  ring_phase_decode #(.CELLS(CELLS), .FINE_W(FINE_W)) u_phase (
    .ring  (ring_state),
    .fine  (dec_fine),
    .legal (dec_legal)
  );

  coarse_pick #(.CELLS(CELLS), .FINE_W(FINE_W), .CW(CW)) u_pick (
    .fine     (dec_fine),
    .rise_val (coarse_rise),
    .fall_val (coarse_fall),
    .picked   (pick_val),
    .use_fall (pick_fall)
  );

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;

  lfsr_rank_engine #(.CW(CW), .TAPS(TAPS), .SEED(SEED)) u_rank (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .target  (pick_val),
    .done    (eng_done),
    .timeout (eng_timeout),
    .index   (eng_index)
  );

  always_comb begin
    adj_index = eng_index;
    if (hold_fall) begin
      adj_index = (eng_index == LAST_IDX) ? '0 : eng_index + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      hold_fine       <= '0;
      hold_bad        <= 1'b0;
      hold_fall       <= 1'b0;
      out_valid       <= 1'b0;
      out_data        <= '0;
      out_err_pattern <= 1'b0;
      out_err_timeout <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            hold_fine <= dec_fine;
            hold_bad  <= !dec_legal;
            hold_fall <= pick_fall;
            state     <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (eng_done || eng_timeout) begin
            out_valid       <= 1'b1;
            out_err_pattern <= hold_bad;
            out_err_timeout <= eng_timeout;
            out_data        <= {(eng_timeout ? {CW{1'b0}} : adj_index), hold_fine};
            state           <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ts_decoder_chk.sv
module ts_decoder_chk #(
  parameter int CW     = 15,
  parameter int FINE_W = 5,
  parameter int OUT_W  = CW + FINE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_err_pattern,
  input logic             out_err_timeout
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst) !(in_ready && out_valid)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> !in_ready); // R9
  AST_BAD_FINE_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && out_err_pattern) |-> (out_data[FINE_W-1:0] == '0)); // R4
  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && out_err_timeout) |-> (out_data[OUT_W-1:FINE_W] == '0)); // R8
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_data[OUT_W-1:FINE_W] != {CW{1'b1}})); // R6
endmodule

bind ts_decoder_top ts_decoder_chk #(.CW(CW), .FINE_W(FINE_W), .OUT_W(OUT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_data        (out_data),
  .out_err_pattern (out_err_pattern),
  .out_err_timeout (out_err_timeout)
);

// File: tb/ts_decoder_top_test.sv
`timescale 1ns/1ps
module ts_decoder_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] ring_state = '0;
  logic [14:0] coarse_rise = '0;
  logic [14:0] coarse_fall = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [19:0] out_data;
  logic        out_err_pattern;
  logic        out_err_timeout;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  ts_decoder_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .ring_state(ring_state), .coarse_rise(coarse_rise), .coarse_fall(coarse_fall),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err_pattern(out_err_pattern), .out_err_timeout(out_err_timeout)
  );

  function automatic logic [15:0] pattern_of(int k);
    logic [16:0] t;
    if (k <= 16) begin
      t = (17'h1 << k) - 17'h1;
      return ~t[15:0];
    end
    t = (17'h1 << (k - 16)) - 17'h1;
    return t[15:0];
  endfunction

  function automatic int legal_bin(logic [15:0] w);
    for (int k = 0; k < 32; k++) if (pattern_of(k) == w) return k;
    return -1;
  endfunction

  function automatic logic [14:0] state_at(int idx);
    logic [14:0] s = 15'h0001;
    for (int i = 0; i < idx; i++) s = {s[13:0], s[14] ^ s[13]};
    return s;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one full transaction: expected values from the requirements
  task automatic run_txn(logic [15:0] ring, int ri, int fi, bit rise_zero, string tag);
    int bin, ef, ec;
    bit ebad, eto, fall_path;
    int wait_cnt;
    logic [19:0] first;
    bin = legal_bin(ring);
    ebad = (bin < 0);
    ef = ebad ? 0 : bin;
    fall_path = !(ef >= 8 && ef <= 23);
    eto = !fall_path && rise_zero;
    if (eto) ec = 0;
    else if (fall_path) ec = (fi == 32766) ? 0 : fi + 1;
    else ec = ri;
    @(negedge clk);
    ring_state = ring;
    coarse_rise = rise_zero ? 15'h0000 : state_at(ri);
    coarse_fall = state_at(fi);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, {tag, " R9 busy"}, 32'(in_ready), 32'd0);
    wait_cnt = 0;
    while (!out_valid && wait_cnt < 40000) begin
      @(negedge clk);
      wait_cnt++;
    end
    first = out_data;
    check(out_data[4:0] == 5'(ef), {tag, " R2 R3 fine"}, 32'(out_data[4:0]), 32'(ef));
    check(out_data[19:5] == 15'(ec), {tag, " R5 R6 R7 R10 coarse"}, 32'(out_data[19:5]), 32'(ec));
    check(out_err_pattern == ebad, {tag, " R4 pattern flag"}, 32'(out_err_pattern), 32'(ebad));
    check(out_err_timeout == eto, {tag, " R8 timeout flag"}, 32'(out_err_timeout), 32'(eto));
    @(negedge clk);
    @(negedge clk);
    check(out_valid && out_data == first, {tag, " R9 hold"}, 32'(out_data), 32'(first));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, {tag, " R9 release"}, 32'(out_valid), 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    logic [15:0] w;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid && in_ready, "R1 reset state", 32'({out_valid, in_ready}), 32'd1);
    // directed corners
    run_txn(pattern_of(0), 3, 9, 1'b0, "bin0");
    run_txn(pattern_of(16), 4, 0, 1'b0, "bin16");
    run_txn(pattern_of(31), 2, 12, 1'b0, "bin31");
    run_txn(pattern_of(7), 11, 5, 1'b0, "bin7");
    run_txn(pattern_of(8), 11, 5, 1'b0, "bin8");
    run_txn(pattern_of(23), 0, 5, 1'b0, "bin23");
    run_txn(pattern_of(24), 6, 20, 1'b0, "bin24");
    run_txn(16'h00F0, 1, 5, 1'b0, "illegal");
    run_txn(pattern_of(10), 0, 3, 1'b1, "zero state");
    run_txn(pattern_of(2), 0, 32766, 1'b0, "wrap");
    // constrained random
    for (int n = 0; n < 40; n++) begin
      if (($urandom % 5) == 0) w = 16'($urandom);
      else w = pattern_of(int'($urandom % 32));
      run_txn(w, int'($urandom % 300), int'($urandom % 300), 1'b0, "random");
    end
    finish_run();
  end
endmodule